// File: doc/BRIEF.md
# Byte-Accessed Seconds Clock With Alarm

This block keeps a free-running seconds count and a matching alarm value, both reached by a host one byte at a time over a small register bus. The count advances on a once-per-second strobe while a run bit in the control byte is set. A new time is loaded through a staging window. The upper bytes are parked in a staging register, and the write to byte 0 loads the whole value into the count in one cycle. A separate window shows the live count, with no snapshot taken. A carry out of the low byte between two byte reads can therefore give a torn value. The host detects a tear when the low byte is smaller on a second read.

An alarm control byte carries a sticky match flag. The flag is set whenever the alarm is enabled and the count equals the alarm value. The interrupt output is the flag gated by the alarm-enable bit. The host acknowledges the flag by writing the alarm control byte with bit 0 at zero.

The register bus has a request channel (`req_valid`/`req_ready`) and a response channel for reads (`rsp_valid`/`rsp_ready`). A request is taken on a clock edge where both `req_valid` and `req_ready` are high. A read returns its byte on the response channel in the following cycle. While a response is waiting and `rsp_ready` is low, the response stays unchanged and `req_ready` stays low, so no request of either kind is taken. Writes produce no response.

Top module: `sec_clock_regs`

## Requirements
- R1: After reset, every register reads zero: control, alarm control, count and alarm value. `alarm_irq` and `rsp_valid` are low, and the count does not advance.
- R2: The control byte (address 0) reads back exactly as written. Bit 7 is the run bit and bit 1 is the alarm-enable bit.
- R3: While the run bit is set, each cycle with `sec_tick` high adds one to the count, and the count wraps from all ones to zero. While the run bit is clear, ticks have no effect.
- R4: Writes to bytes 1 and up of the write window (address 2 is byte 0) leave the count unchanged. A write to byte 0 loads {staged upper bytes, written byte} into the count at the accepting edge.
- R5: A byte-0 load that is accepted in the same cycle as a counted tick takes precedence. The count becomes the loaded value, without the increment.
- R6: The read window (starting at 2+NBYTES) returns the live count bytes, little-endian with byte 0 as the LSB. No snapshot is taken, so a tick between reads is visible.
- R7: The alarm value window (starting at 2+2*NBYTES) holds the alarm value. Its bytes read back as written, little-endian.
- R8: When the alarm-enable bit is set and the count equals the alarm value at a clock edge, bit 0 of the alarm control byte (address 1) is set at that edge. `alarm_irq` then equals that flag AND the alarm-enable bit.
- R9: Writing the alarm control byte with bit 0 at zero clears the flag, unless a match sets it in the same cycle. Writing bit 0 as one never sets it. Bits 7..1 of the alarm control byte read back as written.
- R10: Clearing the alarm-enable bit drops `alarm_irq` at once, and no match sets the flag while that bit is clear.
- R11: A read returns its data one cycle after acceptance. While `rsp_valid` is high and `rsp_ready` is low, the data holds and `req_ready` is low.
- R12: Addresses beyond the alarm window read zero and writes to them change nothing. Reads of the write window return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Host takes the read data |
| rsp_rdata | output | 8 | Read byte |
| alarm_irq | output | 1 | Alarm interrupt level |

## Verification
The bench builds the block with CNT_W=16 and ADDR_W=4. With these values the whole count fits in two bytes, so wrap from 0xFFFF is one tick away after a load. Sixteen addresses leave eight unmapped addresses to probe. A sweep over every low-byte value loads the count, reads it back and ticks it, so each carry from byte 0 into byte 1 is checked against a value the bench computes itself. The same size makes the alarm match, the live-read tear, the load-versus-tick collision and response back-pressure cheap to set up exactly.

// File: rtl/sec_clock_pkg.sv
package sec_clock_pkg;
  localparam int CTL_RUN_BIT   = 7;
  localparam int CTL_ALM_BIT   = 1;
  localparam int ACTL_FLAG_BIT = 0;
  localparam int CTL_ADDR      = 0;
  localparam int ACTL_ADDR     = 1;
  localparam int WWIN_BASE     = 2;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_CTRL,
    RG_ACTL,
    RG_WWIN,
    RG_RWIN,
    RG_ALRM
  } region_e;
endpackage

// File: rtl/sec_clock_bus.sv
module sec_clock_bus
  import sec_clock_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NBYTES = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_rdata,
  input  logic [7:0]        rd_byte,
  output region_e           sel_region,
  output logic [IDX_W-1:0]  sel_idx,
  output logic              wr_fire
);
  localparam int RWIN_BASE = WWIN_BASE + NBYTES;
  localparam int ALRM_BASE = WWIN_BASE + 2 * NBYTES;
  localparam int MAP_END   = WWIN_BASE + 3 * NBYTES;

  logic              fire;
  logic [ADDR_W-1:0] off;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign wr_fire   = fire && req_write;

  always_comb begin
    sel_region = RG_NONE;
    off        = '0;
    if (int'(req_addr) == CTL_ADDR) begin
      sel_region = RG_CTRL;
    end else if (int'(req_addr) == ACTL_ADDR) begin
      sel_region = RG_ACTL;
    end else if (int'(req_addr) < RWIN_BASE) begin
      sel_region = RG_WWIN;
      off        = req_addr - ADDR_W'(WWIN_BASE);
    end else if (int'(req_addr) < ALRM_BASE) begin
      sel_region = RG_RWIN;
      off        = req_addr - ADDR_W'(RWIN_BASE);
    end else if (int'(req_addr) < MAP_END) begin
      sel_region = RG_ALRM;
      off        = req_addr - ADDR_W'(ALRM_BASE);
    end
    sel_idx = off[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (fire && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_byte;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sec_clock_counter.sv
module sec_clock_counter #(
  parameter int CNT_W  = 32,
  parameter int NBYTES = 4,
  parameter int IDX_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             stage_we,
  input  logic [IDX_W-1:0] stage_idx,
  input  logic [7:0]       wbyte,
  output logic             commit,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:8] stage_q;

  assign commit = stage_we && (stage_idx == '0);

  for (genvar b = 1; b < NBYTES; b++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage_q[b*8 +: 8] <= '0;
      end else if (stage_we && stage_idx == IDX_W'(b)) begin
        stage_q[b*8 +: 8] <= wbyte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (commit) begin
      count <= {stage_q, wbyte};
    end else if (run && tick) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/sec_clock_alarm.sv
module sec_clock_alarm #(
  parameter int CNT_W  = 32,
  parameter int NBYTES = 4,
  parameter int IDX_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             alm_en,
  input  logic             val_we,
  input  logic [IDX_W-1:0] val_idx,
  input  logic             actl_we,
  input  logic [7:0]       wbyte,
  output logic [CNT_W-1:0] alarm_val,
  output logic [7:0]       actl,
  output logic             irq
);
  logic hit;
  logic flag_q;
  logic [7:1] spare_q;

  for (genvar b = 0; b < NBYTES; b++) begin : g_val
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        alarm_val[b*8 +: 8] <= '0;
      end else if (val_we && val_idx == IDX_W'(b)) begin
        alarm_val[b*8 +: 8] <= wbyte;
      end
    end
  end

  assign hit = alm_en && (count == alarm_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      spare_q <= '0;
    end else begin
      if (actl_we) spare_q <= wbyte[7:1];
      if (hit) begin
        flag_q <= 1'b1;
      end else if (actl_we && !wbyte[0]) begin
        flag_q <= 1'b0;
      end
    end
  end

  assign actl = {spare_q, flag_q};
  assign irq  = flag_q && alm_en;
endmodule

// File: rtl/sec_clock_regs.sv
module sec_clock_regs
  import sec_clock_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_rdata,
  output logic              alarm_irq
);
  localparam int NBYTES = CNT_W / 8;
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  region_e          sel_region;
  logic [IDX_W-1:0] sel_idx;
  logic             wr_fire;
  logic [7:0]       rd_byte;
  logic [7:0]       ctrl_q;
  logic [7:0]       actl;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] alarm_val;
  logic             commit;

  sec_clock_bus #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .IDX_W(IDX_W)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .rd_byte   (rd_byte),
    .sel_region(sel_region),
    .sel_idx   (sel_idx),
    .wr_fire   (wr_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_fire && sel_region == RG_CTRL) begin
      ctrl_q <= req_wdata;
    end
  end

  sec_clock_counter #(.CNT_W(CNT_W), .NBYTES(NBYTES), .IDX_W(IDX_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sec_tick),
    .run      (ctrl_q[CTL_RUN_BIT]),
    .stage_we (wr_fire && sel_region == RG_WWIN),
    .stage_idx(sel_idx),
    .wbyte    (req_wdata),
    .commit   (commit),
    .count    (count_q)
  );

  sec_clock_alarm #(.CNT_W(CNT_W), .NBYTES(NBYTES), .IDX_W(IDX_W)) u_alm (
    .clk      (clk),
    .rst_n    (rst_n),
    .count    (count_q),
    .alm_en   (ctrl_q[CTL_ALM_BIT]),
    .val_we   (wr_fire && sel_region == RG_ALRM),
    .val_idx  (sel_idx),
    .actl_we  (wr_fire && sel_region == RG_ACTL),
    .wbyte    (req_wdata),
    .alarm_val(alarm_val),
    .actl     (actl),
    .irq      (alarm_irq)
  );

  always_comb begin
    unique case (sel_region)
      RG_CTRL: rd_byte = ctrl_q;
      RG_ACTL: rd_byte = actl;
      RG_RWIN: rd_byte = count_q[sel_idx*8 +: 8];
      RG_ALRM: rd_byte = alarm_val[sel_idx*8 +: 8];
      default: rd_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/sec_clock_regs_chk.sv
module sec_clock_regs_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             run,
  input logic             commit,
  input logic [7:0]       wbyte,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] alarm_val,
  input logic             alm_en,
  input logic             flag,
  input logic             irq,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [7:0]       rsp_rdata
);
  AST_TICK_INC: assert property (@(posedge clk) disable iff (!rst_n)
    run && tick && !commit |=> count == CNT_W'($past(count) + 1'b1)); // R3
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && tick) && !commit |=> $stable(count)); // R3
  AST_COMMIT_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> count[7:0] == $past(wbyte)); // R5
  AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    alm_en && count == alarm_val |=> flag); // R8
  AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(alm_en && count == alarm_val)); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !alm_en |-> !irq); // R10
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R11
  AST_RSP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R11
endmodule

bind sec_clock_regs sec_clock_regs_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (sec_tick),
  .run      (ctrl_q[7]),
  .commit   (commit),
  .wbyte    (req_wdata),
  .count    (count_q),
  .alarm_val(alarm_val),
  .alm_en   (ctrl_q[1]),
  .flag     (actl[0]),
  .irq      (alarm_irq),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata)
);

// File: tb/sim_sec_clock_regs.sv
module sim_sec_clock_regs;
  localparam int CW = 16;
  localparam int AW = 4;
  localparam logic [AW-1:0] A_CTL = 0, A_ACTL = 1, A_WW = 2, A_RW = 4, A_AL = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sec_tick = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [7:0]    rsp_rdata;
  logic          alarm_irq;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  sec_clock_regs #(.CNT_W(CW), .ADDR_W(AW)) u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic tick1();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic load(input logic [15:0] v);
    wr(A_WW + 1, v[15:8]);
    wr(A_WW, v[7:0]);
  endtask

  task automatic read_cnt(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(A_RW, lo);
    rd(A_RW + 1, hi);
    v = {hi, lo};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", alarm_irq, 0);
    check("R1 rsp_valid", rsp_valid, 0);
    rd(A_CTL, b);  check("R1 ctrl", b, 0);
    rd(A_ACTL, b); check("R1 actl", b, 0);
    read_cnt(v);   check("R1 count", v, 0);
    rd(A_AL, b);   check("R1 alarm lo", b, 0);
    rd(A_AL + 1, b); check("R1 alarm hi", b, 0);
    tick1();
    read_cnt(v);   check("R1 stopped after reset", v, 0);

    // R2 control readback
    wr(A_CTL, 8'h7D); rd(A_CTL, b); check("R2 ctrl 7D", b, 8'h7D);
    wr(A_CTL, 8'hA5); rd(A_CTL, b); check("R2 ctrl A5", b, 8'hA5);
    wr(A_CTL, 8'h00);

    // R3 disabled ticks ignored, enabled ticks count
    tick1(); tick1();
    read_cnt(v); check("R3 run clear", v, 0);
    wr(A_CTL, 8'h80);
    tick1(); tick1(); tick1();
    read_cnt(v); check("R3 three ticks", v, 3);

    // R4 staging does not touch count; byte 0 loads
    wr(A_WW + 1, 8'h12);
    read_cnt(v); check("R4 staged only", v, 3);
    wr(A_WW, 8'h34);
    read_cnt(v); check("R4 load", v, 16'h1234);

    // R4/R6/R3 sweep over every low byte value
    for (int i = 0; i < 256; i++) begin
      logic [15:0] e;
      e = {8'(i) ^ 8'h5A, 8'(i)};
      load(e);
      read_cnt(v); check("R4 sweep load", v, e);
      tick1();
      read_cnt(v); check("R6 sweep tick", v, 16'(e + 16'd1));
    end

    // R3 wrap
    load(16'hFFFF); tick1();
    read_cnt(v); check("R3 wrap", v, 0);

    // R5 load beats tick in same cycle
    wr(A_WW + 1, 8'h40);
    @(negedge clk);
    sec_tick = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = A_WW; req_wdata = 8'h10;
    @(negedge clk);
    sec_tick = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    read_cnt(v); check("R5 load over tick", v, 16'h4010);

    // R6 live read: low byte drops after carry
    load(16'h00FF);
    rd(A_RW, b); check("R6 lsb before", b, 8'hFF);
    tick1();
    rd(A_RW, b); check("R6 lsb after carry", b, 8'h00);
    rd(A_RW + 1, b); check("R6 msb after carry", b, 8'h01);

    // R7 alarm value readback
    wr(A_AL, 8'hC3); wr(A_AL + 1, 8'h9E);
    rd(A_AL, b); check("R7 alarm lo", b, 8'hC3);
    rd(A_AL + 1, b); check("R7 alarm hi", b, 8'h9E);

    // R8 match sets flag and irq
    wr(A_AL, 8'h50); wr(A_AL + 1, 8'h00);
    load(16'h004F);
    wr(A_CTL, 8'h82);
    @(negedge clk);
    check("R8 no irq before match", alarm_irq, 0);
    tick1();
    @(negedge clk);
    check("R8 irq on match", alarm_irq, 1);
    rd(A_ACTL, b); check("R8 flag bit0", b, 8'h01);

    // R9 clear and no set by writing one
    tick1();
    wr(A_ACTL, 8'h00);
    rd(A_ACTL, b); check("R9 cleared", b, 8'h00);
    check("R9 irq low", alarm_irq, 0);
    wr(A_ACTL, 8'h01);
    rd(A_ACTL, b); check("R9 write one no set", b, 8'h00);
    wr(A_ACTL, 8'hF0);
    rd(A_ACTL, b); check("R9 upper bits", b, 8'hF0);
    wr(A_ACTL, 8'h00);

    // R10 disabling alarm drops irq, no set while disabled
    load(16'h004F); tick1(); @(negedge clk);
    check("R10 irq set again", alarm_irq, 1);
    wr(A_CTL, 8'h80);
    check("R10 irq drops", alarm_irq, 0);
    wr(A_ACTL, 8'h00);
    load(16'h0050); @(negedge clk); @(negedge clk);
    rd(A_ACTL, b); check("R10 no set when disabled", b, 8'h00);
    check("R10 irq stays low", alarm_irq, 0);

    // R11 response back-pressure
    wr(A_CTL, 8'h00);
    wr(A_CTL, 8'h6C);
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = A_CTL;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 rsp valid", rsp_valid, 1);
    check("R11 ready low", req_ready, 0);
    @(negedge clk); @(negedge clk);
    check("R11 held valid", rsp_valid, 1);
    check("R11 held data", rsp_rdata, 8'h6C);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R11 drained", rsp_valid, 0);
    check("R11 ready back", req_ready, 1);

    // R12 unmapped and write window reads
    for (int a = 8; a < 16; a++) begin
      wr(AW'(a), 8'hFF);
      rd(AW'(a), b); check("R12 unmapped", b, 0);
    end
    rd(A_CTL, b); check("R12 ctrl untouched", b, 8'h6C);
    read_cnt(v); check("R12 count untouched", v, 16'h0050);
    wr(A_WW + 1, 8'h77);
    rd(A_WW + 1, b); check("R12 wwin reads zero", b, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule